// File: doc/BRIEF.md
# Half-Duplex SPI Master

This block is a register-programmed SPI master that moves bytes in one direction per transfer. Software picks transmit or receive with a direction bit and loads a byte total. In transmit, it then feeds bytes into an 8-deep byte FIFO, and the engine shifts each one out on MOSI. In receive, the engine clocks dummy all-ones bytes and captures MISO into the FIFO, where software pops them. Chip select is left to ordinary GPIO.

The serial clock is the system clock divided by an 8-bit divisor, which has a floor of 2. Only the two SPI modes that sample on the rising edge are offered: mode 0 (idle low) and mode 3 (idle high). Bit order is selectable. A three-wire option moves the data onto the bidirectional MISO line. Sticky status flags, masked by an enable register, form one interrupt line. The engine stalls at a byte boundary, with SCK at its idle level, whenever the FIFO cannot feed it or cannot take the next byte.

Top module: `spi_hd_master`

## Requirements
- R1: After reset the registers read as follows: control 0, divisor 2, flags 0x40, count 0, level 0. SCK, MOSI, the shared-line enable and irq are all 0. The register addresses are: control 0, divisor 1, irq enable 2, flags 3, count 4, data 5, level 6.
- R2: While a byte is in flight, each SCK high phase lasts div/2 clocks and each low phase lasts div-div/2 clocks (integer division). A divisor write below 2 is stored as 2.
- R3: Control bit 0 sets the SCK idle level (0 = low, mode 0; 1 = high, mode 3). Outgoing data changes only at a falling SCK edge or at byte start. Incoming data is sampled at the rising edge.
- R4: With control bit 1 = 0 (transmit), each byte is popped from the FIFO and sent as 8 bits on MOSI, MSB first when control bit 2 = 0.
- R5: With control bit 2 = 1, bits are sent and assembled LSB first, in both directions.
- R6: With control bit 1 = 1 (receive), MOSI is held at 1 through each byte. Each received byte is pushed into the FIFO. Each read of the data register pops one byte.
- R7: The count register drops by one as each byte completes. Flags bit 1 (byte end) sets on every byte. Flags bit 0 (count end) sets when the count reaches 0. Flags bit 6 (free) reads 1 only while the engine is idle and the count is 0.
- R8: In transmit, if the count is nonzero and the FIFO is empty, SCK stays at its idle level and the count holds.
- R9: In receive, if the FIFO is full, no further byte is clocked and no data is lost.
- R10: Writing control bit 7 empties the FIFO, zeroes the count and clears every flag. The bit reads back 0.
- R11: Flags bit 2 sets while the FIFO holds 4 or more bytes. Flags bit 3 sets on a data write to a full FIFO in transmit, or on a data read of an empty FIFO in receive. Writing 1 to a flag bit clears it. irq is the OR of the flags ANDed with the enable register.
- R12: With control bit 3 = 1 (three-wire), the shared-line output enable equals the transmit direction. Transmit data goes out on the shared line, MOSI stays 0, and received data is taken from the shared line.
- R13: The level register reads the FIFO occupancy, from 0 to 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid while bus_sel is high |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out (four-wire) |
| spi_miso_i | input | 1 | Serial data in / shared line input |
| spi_miso_o | output | 1 | Shared line output value |
| spi_miso_oe | output | 1 | Shared line output enable |
| irq | output | 1 | Masked flag interrupt |

## Verification
A wrong phase counter shows up at once as an SCK high or low stretch of the wrong length, and the per-clock phase monitor flags it on the first edge. A wrong bit index or shift direction corrupts the byte the bench-side slave captures, or the byte popped back out of the FIFO, so it shows within one byte time. Faulty count, stall or FIFO pointer logic shows as a wrong level or count register, or as a flags word that differs from the model, read back at a byte boundary or after a stall interval.

// File: rtl/spi_hd_pkg.sv
`timescale 1ns/1ps
package spi_hd_pkg;
    // control fields, bit 0 upward: idle level, direction, order, shared line
    typedef struct packed {
        logic three_wire;
        logic lsb_first;
        logic dir_rx;
        logic mode3;
    } spi_cfg_t;

    localparam int unsigned A_CTRL  = 0;
    localparam int unsigned A_DIV   = 1;
    localparam int unsigned A_IE    = 2;
    localparam int unsigned A_FLAG  = 3;
    localparam int unsigned A_CNT   = 4;
    localparam int unsigned A_DATA  = 5;
    localparam int unsigned A_LEVEL = 6;

    localparam int unsigned F_CEND  = 0;
    localparam int unsigned F_BEND  = 1;
    localparam int unsigned F_HALF  = 2;
    localparam int unsigned F_OVF   = 3;
    localparam int unsigned CLR_BIT = 7;
endpackage

// File: rtl/spi_hd_fifo.sv
`timescale 1ns/1ps
module spi_hd_fifo #(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned W     = 8,
    localparam int unsigned PW   = $clog2(DEPTH),
    localparam int unsigned LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          push,
    input  logic [W-1:0]  wdata,
    input  logic          pop,
    output logic [W-1:0]  rdata,
    output logic [LW-1:0] level,
    output logic          full,
    output logic          empty
);
    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PW-1:0]           wp;
        logic [PW-1:0]           rp;
        logic [LW-1:0]           lvl;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic     do_push, do_pop;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full  = (st_q.lvl == LW'(DEPTH));
    assign empty = (st_q.lvl == '0);
    assign rdata = st_q.mem[st_q.rp];
    assign level = st_q.lvl;

    always_comb begin
        st_d    = st_q;
        do_push = push && !full;
        do_pop  = pop && !empty;
        if (clear) begin
            st_d.wp  = '0;
            st_d.rp  = '0;
            st_d.lvl = '0;
        end else begin
            if (do_push) begin
                st_d.mem[st_q.wp] = wdata;
                st_d.wp           = bump(st_q.wp);
            end
            if (do_pop) st_d.rp = bump(st_q.rp);
            st_d.lvl = st_q.lvl + LW'(do_push) - LW'(do_pop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_FIFO_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.lvl <= LW'(DEPTH)) else $error("fifo level above depth"); // R13
endmodule

// File: rtl/spi_hd_engine.sv
`timescale 1ns/1ps
module spi_hd_engine #(
    parameter int unsigned W    = 8,
    parameter int unsigned DIVW = 8,
    localparam int unsigned BW  = $clog2(W)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            abort,
    input  logic            mode3,
    input  logic            lsb_first,
    input  logic            dir_rx,
    input  logic [DIVW-1:0] div,
    input  logic            can_start,
    input  logic [W-1:0]    tx_byte,
    input  logic            sdi,
    output logic            start,
    output logic            done,
    output logic            busy,
    output logic [W-1:0]    rx_byte,
    output logic            sck,
    output logic            sdo
);
    typedef struct packed {
        logic            run;
        logic            half;
        logic [DIVW-1:0] tick;
        logic [BW-1:0]   bitn;
        logic [W-1:0]    txb;
        logic [W-1:0]    rxb;
    } eng_st_t;

    eng_st_t         st_d, st_q;
    logic [DIVW-1:0] len_lo, len_hi;
    logic [BW-1:0]   idx;

    assign len_hi = div >> 1;
    assign len_lo = div - len_hi;

    always_comb begin
        st_d  = st_q;
        start = 1'b0;
        done  = 1'b0;
        if (abort) begin
            st_d.run = 1'b0;
        end else if (!st_q.run) begin
            if (can_start) begin
                st_d.run  = 1'b1;
                st_d.half = 1'b0;
                st_d.tick = '0;
                st_d.bitn = '0;
                st_d.txb  = dir_rx ? '1 : tx_byte;
                start     = 1'b1;
            end
        end else if (!st_q.half) begin
            if (st_q.tick == len_lo - 1'b1) begin
                st_d.half = 1'b1;
                st_d.tick = '0;
                st_d.rxb  = lsb_first ? {sdi, st_q.rxb[W-1:1]}
                                      : {st_q.rxb[W-2:0], sdi};
            end else begin
                st_d.tick = st_q.tick + 1'b1;
            end
        end else begin
            if (st_q.tick == len_hi - 1'b1) begin
                st_d.half = 1'b0;
                st_d.tick = '0;
                if (st_q.bitn == BW'(W - 1)) begin
                    st_d.run = 1'b0;
                    done     = 1'b1;
                end else begin
                    st_d.bitn = st_q.bitn + 1'b1;
                end
            end else begin
                st_d.tick = st_q.tick + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign idx     = lsb_first ? st_q.bitn : BW'(W - 1) - st_q.bitn;
    assign sck     = st_q.run ? st_q.half : mode3;
    assign sdo     = st_q.run ? st_q.txb[idx] : 1'b0;
    assign busy    = st_q.run;
    assign rx_byte = st_q.rxb;

    AST_SDO_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.run && $rose(sck)) |-> $stable(sdo)) else $error("data moved at rising edge"); // R3
endmodule

// File: rtl/spi_hd_master.sv
`timescale 1ns/1ps
module spi_hd_master
    import spi_hd_pkg::*;
#(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned DW    = 8,
    parameter int unsigned CW    = 16,
    parameter int unsigned DIVW  = 8,
    parameter int unsigned AW    = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [CW-1:0] bus_wdata,
    output logic [CW-1:0] bus_rdata,
    output logic          spi_sck,
    output logic          spi_mosi,
    input  logic          spi_miso_i,
    output logic          spi_miso_o,
    output logic          spi_miso_oe,
    output logic          irq
);
    localparam int unsigned LW = $clog2(DEPTH + 1);

    typedef struct packed {
        spi_cfg_t        cfg;
        logic [DIVW-1:0] div;
        logic [3:0]      ie;
        logic [3:0]      flg;
        logic [CW-1:0]   cnt;
    } reg_st_t;

    reg_st_t       rg_d, rg_q;
    logic          wr_ctrl, wr_div, wr_ie, wr_flg, wr_cnt, wr_data, rd_data, clr;
    logic          f_push, f_pop, f_full, f_empty, ovf_ev, free;
    logic [DW-1:0] f_wdata, f_rdata, e_rx;
    logic [LW-1:0] f_level;
    logic          e_start, e_done, e_busy, e_sdo, can_start;
    logic [3:0]    flg_set, flg_keep;

    assign wr_ctrl = bus_sel && bus_wr && (bus_addr == AW'(A_CTRL));
    assign wr_div  = bus_sel && bus_wr && (bus_addr == AW'(A_DIV));
    assign wr_ie   = bus_sel && bus_wr && (bus_addr == AW'(A_IE));
    assign wr_flg  = bus_sel && bus_wr && (bus_addr == AW'(A_FLAG));
    assign wr_cnt  = bus_sel && bus_wr && (bus_addr == AW'(A_CNT));
    assign wr_data = bus_sel && bus_wr && (bus_addr == AW'(A_DATA));
    assign rd_data = bus_sel && !bus_wr && (bus_addr == AW'(A_DATA));
    assign clr     = wr_ctrl && bus_wdata[CLR_BIT];

    assign f_push  = rg_q.cfg.dir_rx ? e_done : wr_data;
    assign f_wdata = rg_q.cfg.dir_rx ? e_rx : bus_wdata[DW-1:0];
    assign f_pop   = rg_q.cfg.dir_rx ? (rd_data && !f_empty) : e_start;
    assign ovf_ev  = rg_q.cfg.dir_rx ? (rd_data && f_empty) : (wr_data && f_full);

    assign can_start = (rg_q.cnt != '0) && !clr &&
                       (rg_q.cfg.dir_rx ? !f_full : !f_empty);
    assign free = !e_busy && (rg_q.cnt == '0);

    spi_hd_fifo #(.DEPTH(DEPTH), .W(DW)) u_fifo (
        .clk(clk), .rst_n(rst_n), .clear(clr), .push(f_push), .wdata(f_wdata),
        .pop(f_pop), .rdata(f_rdata), .level(f_level), .full(f_full), .empty(f_empty)
    );

    spi_hd_engine #(.W(DW), .DIVW(DIVW)) u_eng (
        .clk(clk), .rst_n(rst_n), .abort(clr), .mode3(rg_q.cfg.mode3),
        .lsb_first(rg_q.cfg.lsb_first), .dir_rx(rg_q.cfg.dir_rx), .div(rg_q.div),
        .can_start(can_start), .tx_byte(f_rdata), .sdi(spi_miso_i),
        .start(e_start), .done(e_done), .busy(e_busy), .rx_byte(e_rx),
        .sck(spi_sck), .sdo(e_sdo)
    );

    always_comb begin
        rg_d     = rg_q;
        flg_set  = '0;
        flg_keep = rg_q.flg;
        if (wr_ctrl) rg_d.cfg = spi_cfg_t'(bus_wdata[3:0]);
        if (wr_div)  rg_d.div = (bus_wdata[DIVW-1:0] < DIVW'(2)) ? DIVW'(2)
                                                                 : bus_wdata[DIVW-1:0];
        if (wr_ie)   rg_d.ie  = bus_wdata[3:0];
        if (clr)                          rg_d.cnt = '0;
        else if (wr_cnt)                  rg_d.cnt = bus_wdata;
        else if (e_done && rg_q.cnt != '0) rg_d.cnt = rg_q.cnt - 1'b1;
        flg_set[F_BEND] = e_done;
        flg_set[F_CEND] = e_done && (rg_q.cnt == CW'(1)) && !wr_cnt;
        flg_set[F_HALF] = (f_level >= LW'(DEPTH / 2));
        flg_set[F_OVF]  = ovf_ev;
        if (wr_flg) flg_keep = rg_q.flg & ~bus_wdata[3:0];
        rg_d.flg = clr ? '0 : (flg_keep | flg_set);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rg_q     <= '0;
            rg_q.div <= DIVW'(2);
        end else begin
            rg_q <= rg_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            AW'(A_CTRL):  bus_rdata = {{(CW-4){1'b0}}, rg_q.cfg};
            AW'(A_DIV):   bus_rdata = {{(CW-DIVW){1'b0}}, rg_q.div};
            AW'(A_IE):    bus_rdata = {{(CW-4){1'b0}}, rg_q.ie};
            AW'(A_FLAG):  bus_rdata = {{(CW-7){1'b0}}, free, 2'b00, rg_q.flg};
            AW'(A_CNT):   bus_rdata = rg_q.cnt;
            AW'(A_DATA):  bus_rdata = {{(CW-DW){1'b0}}, f_rdata};
            AW'(A_LEVEL): bus_rdata = {{(CW-LW){1'b0}}, f_level};
            default:      bus_rdata = '0;
        endcase
    end

    assign spi_mosi    = rg_q.cfg.three_wire ? 1'b0 : e_sdo;
    assign spi_miso_o  = e_sdo;
    assign spi_miso_oe = rg_q.cfg.three_wire && !rg_q.cfg.dir_rx;
    assign irq         = |(rg_q.flg & rg_q.ie);

    AST_DIV_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        rg_q.div >= DIVW'(2)) else $error("divisor below floor"); // R2
    AST_TX_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (e_start && !rg_q.cfg.dir_rx) |-> !f_empty) else $error("tx start on empty"); // R8
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (e_done && rg_q.cfg.dir_rx) |-> !f_full) else $error("rx byte into full fifo"); // R9
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (e_done && rg_q.cnt != '0 && !clr && !wr_cnt) |=> (rg_q.cnt == $past(rg_q.cnt) - 1'b1))
        else $error("count did not step"); // R7
endmodule

// File: tb/sim_spi_hd_master.sv
`timescale 1ns/1ps
module sim_spi_hd_master;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        spi_sck, spi_mosi, spi_miso_i, spi_miso_o, spi_miso_oe, irq;

    always #2.5 clk = ~clk;

    spi_hd_master u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso_i(spi_miso_i),
        .spi_miso_o(spi_miso_o), .spi_miso_oe(spi_miso_oe), .irq(irq)
    );

    int total = 0;
    int bad = 0;

    task automatic chk_eq(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    function automatic logic [7:0] pat(int k);
        return 8'((k * 37 + 5) & 255);
    endfunction

    function automatic logic [7:0] rev8(logic [7:0] b);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = b[7-i];
        return r;
    endfunction

    // bench-side slave: shifts captured bits MSB-first, serves pat(k) MSB-first
    int         s_bits = 0;
    int         s_byte = 0;
    logic [7:0] s_cap = '0;
    logic [7:0] cap_q[$];
    bit         three = 1'b0;
    logic [7:0] s_cur;

    always_comb begin
        s_cur      = pat(s_byte);
        spi_miso_i = s_cur[7 - s_bits];
    end

    always @(posedge spi_sck) begin
        s_cap = {s_cap[6:0], (three ? spi_miso_o : spi_mosi)};
        #1;
        if (s_bits == 7) begin
            cap_q.push_back(s_cap);
            s_bits = 0;
            s_byte++;
        end else begin
            s_bits++;
        end
    end

    task automatic sreset();
        s_bits = 0;
        s_byte = 0;
        cap_q.delete();
    endtask

    // per-clock reference for SCK phase lengths
    bit   mon_on = 1'b0;
    int   mdiv = 2;
    bit   mmode3 = 1'b0;
    int   run_len = 0;
    logic prev_sck = 1'b0;
    bit   mosi_seen = 1'b0;

    always @(negedge clk) begin
        if (three && spi_mosi) mosi_seen = 1'b1;
        if (!mon_on) begin
            run_len  = 0;
            prev_sck = spi_sck;
        end else if (spi_sck == prev_sck) begin
            run_len++;
        end else begin
            if (prev_sck != mmode3)
                chk_eq("R2 sck phase length", run_len,
                       mmode3 ? (mdiv - mdiv / 2) : (mdiv / 2));
            run_len  = 1;
            prev_sck = spi_sck;
        end
    end

    task automatic wr(int a, int d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 3'(a); bus_wdata = 16'(d);
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(int a, output int d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 3'(a);
        #1 d = int'(bus_rdata);
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic wait_free(string tag);
        int f;
        for (int i = 0; i < 2000; i++) begin
            rd(3, f);
            if (f[6]) return;
        end
        chk_eq({tag, " free timeout"}, 0, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        summary();
    end

    initial begin
        int v;
        logic [7:0] tx[3];
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(0, v); chk_eq("R1 ctrl", v, 0);
        rd(1, v); chk_eq("R1 div", v, 2);
        rd(3, v); chk_eq("R1 flags", v, 'h40);
        rd(4, v); chk_eq("R1 count", v, 0);
        rd(6, v); chk_eq("R1 level", v, 0);
        chk_eq("R1 sck", int'(spi_sck), 0);
        chk_eq("R1 mosi", int'(spi_mosi), 0);
        chk_eq("R1 oe", int'(spi_miso_oe), 0);
        chk_eq("R1 irq", int'(irq), 0);

        // R2 divisor floor
        wr(1, 1); rd(1, v); chk_eq("R2 div floor 1", v, 2);
        wr(1, 0); rd(1, v); chk_eq("R2 div floor 0", v, 2);
        wr(1, 4); rd(1, v); chk_eq("R2 div 4", v, 4);

        // R4 transmit mode 0 MSB-first, div 4
        wr(0, 0); sreset(); mdiv = 4; mmode3 = 0; mon_on = 1;
        tx[0] = 8'h3C; tx[1] = 8'hA5; tx[2] = 8'h01;
        for (int i = 0; i < 3; i++) wr(5, tx[i]);
        rd(6, v); chk_eq("R13 level after pushes", v, 3);
        wr(4, 3);
        wait_free("R4");
        chk_eq("R4 byte count", cap_q.size(), 3);
        for (int i = 0; i < 3; i++)
            if (i < cap_q.size()) chk_eq("R4 tx byte", cap_q[i], tx[i]);
        rd(3, v); chk_eq("R7 flags after tx", v, 'h43);
        rd(4, v); chk_eq("R7 count zero", v, 0);
        rd(6, v); chk_eq("R13 level drained", v, 0);
        wr(3, 3); rd(3, v); chk_eq("R11 w1c", v, 'h40);

        // R8 transmit stall, mode 3, LSB-first, div 3
        mon_on = 0;
        wr(0, 'h05); wr(1, 3); sreset(); mdiv = 3; mmode3 = 1;
        repeat (2) @(negedge clk);
        mon_on = 1;
        wr(5, 'h96); wr(4, 2);
        repeat (80) @(negedge clk);
        rd(4, v); chk_eq("R8 count holds", v, 1);
        chk_eq("R8 sck idle high", int'(spi_sck), 1);
        rd(3, v); chk_eq("R8 flags stalled", v, 'h02);
        chk_eq("R5 first lsb byte count", cap_q.size(), 1);
        if (cap_q.size() > 0) chk_eq("R5 lsb byte 0", cap_q[0], rev8(8'h96));
        wr(5, 'h0F);
        wait_free("R8");
        if (cap_q.size() > 1) chk_eq("R5 lsb byte 1", cap_q[1], rev8(8'h0F));
        else chk_eq("R5 lsb byte 1 missing", cap_q.size(), 2);
        rd(3, v); chk_eq("R7 flags after stall", v, 'h43);
        wr(3, 'hF);

        // R6 receive mode 0 MSB-first, div 2
        mon_on = 0;
        wr(0, 'h02); wr(1, 2); sreset(); mdiv = 2; mmode3 = 0;
        repeat (2) @(negedge clk);
        mon_on = 1;
        wr(4, 3);
        wait_free("R6");
        rd(6, v); chk_eq("R13 rx level", v, 3);
        for (int i = 0; i < 3; i++) begin
            rd(5, v); chk_eq("R6 rx byte", v, pat(i));
        end
        for (int i = 0; i < cap_q.size(); i++) chk_eq("R6 dummy out", cap_q[i], 'hFF);
        wr(3, 'hF);

        // R9 receive stall on full fifo
        sreset();
        wr(4, 10);
        repeat (300) @(negedge clk);
        rd(6, v); chk_eq("R9 level full", v, 8);
        rd(4, v); chk_eq("R9 count holds", v, 2);
        rd(3, v); chk_eq("R11 half flag", v, 'h06);
        chk_eq("R9 sck idle", int'(spi_sck), 0);
        for (int i = 0; i < 8; i++) begin
            rd(5, v); chk_eq("R9 rx byte", v, pat(i));
        end
        wait_free("R9");
        for (int i = 8; i < 10; i++) begin
            rd(5, v); chk_eq("R9 tail byte", v, pat(i));
        end
        wr(3, 'hF); rd(3, v); chk_eq("R11 flags cleared", v, 'h40);

        // R11 overflow and irq, R10 clear
        mon_on = 0;
        rd(5, v);
        rd(3, v); chk_eq("R11 ovf on empty pop", v, 'h48);
        wr(2, 'h8);
        chk_eq("R11 irq", int'(irq), 1);
        wr(0, 0);
        for (int i = 0; i < 9; i++) wr(5, i + 1);
        rd(6, v); chk_eq("R13 level max", v, 8);
        rd(3, v); chk_eq("R11 ovf and half", v, 'h4C);
        wr(0, 'h80);
        rd(6, v); chk_eq("R10 level cleared", v, 0);
        rd(3, v); chk_eq("R10 flags cleared", v, 'h40);
        rd(0, v); chk_eq("R10 clear bit reads 0", v, 0);
        chk_eq("R10 irq low", int'(irq), 0);
        sreset();
        wr(4, 5); rd(4, v); chk_eq("R8 count loaded", v, 5);
        wr(0, 'h80); rd(4, v); chk_eq("R10 count cleared", v, 0);
        chk_eq("R8 nothing sent", cap_q.size(), 0);

        // R12 three-wire transmit then receive
        wr(0, 'h08); sreset(); three = 1; mosi_seen = 0;
        chk_eq("R12 oe in tx", int'(spi_miso_oe), 1);
        wr(5, 'h5A); wr(4, 1);
        wait_free("R12");
        if (cap_q.size() > 0) chk_eq("R12 shared tx byte", cap_q[0], 'h5A);
        else chk_eq("R12 shared tx missing", 0, 1);
        chk_eq("R12 mosi quiet", int'(mosi_seen), 0);
        wr(0, 'h0E); sreset();
        chk_eq("R12 oe in rx", int'(spi_miso_oe), 0);
        wr(4, 1);
        wait_free("R12 rx");
        rd(5, v); chk_eq("R5 R12 shared lsb rx", v, rev8(pat(0)));

        summary();
    end
endmodule